// File: doc/BRIEF.md
# I2C Register Target with Auto-Increment

This block is an I2C target that lets a bus controller read and write a byte-wide register file kept outside the block. SCL and SDA are oversampled by the system clock through two-flop synchronisers. Start and stop are recognised from SDA edges while SCL is high. SDA is only ever pulled low, through an open-drain output enable. A strap input chooses one of two fixed 7-bit device addresses.

A write transaction sends the device address with the write bit, then the register pointer, then any number of data bytes. Each data byte causes a write strobe at the pointer, and the pointer then steps by one. A read transaction first loads the pointer with a write. The controller then issues a repeated start and the device address with the read bit. The target returns the register at the pointer and steps the pointer after every byte it sends. It keeps sending until the controller answers a byte with NACK.

The register file sits on a simple port. `reg_addr` always shows the pointer. `reg_rdata` must be a combinational function of `reg_addr`. `reg_wr` and `reg_rd` are one-cycle strobes.

Top module: `i2c_regbus_target`

## Requirements
- R1: After reset the target does not drive SDA (`sda_oe` = 0) and raises neither `reg_wr` nor `reg_rd`.
- R2: The address byte carries the 7-bit device address in bits 7:1 and the direction in bit 0 (1 = read). The device address is 0x34 when `addr_sel` = 0 and 0x30 when `addr_sel` = 1. A matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R3: When the address does not match, the target neither acknowledges nor drives SDA. It raises no strobe until the next start or stop.
- R4: In a write transaction, the target acknowledges the pointer byte and every data byte. Each data byte produces one `reg_wr` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R5: Successive data bytes in one write transaction go to successive addresses. The pointer wraps from 0xFF to 0x00.
- R6: After a repeated start with the read bit set, the target sends the register at the pointer, MSB first. It raises `reg_rd` once for each byte it loads.
- R7: In a burst read, the pointer advances after every byte sent. A NACK from the controller ends the burst, and the target leaves SDA released.
- R8: The target changes its SDA drive only while SCL is low. It releases SDA after each acknowledge clock.
- R9: The pointer keeps its value between transactions, so a read without a preceding pointer write continues where the last access left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap: 0 selects address 0x34, 1 selects 0x30 |
| scl_in | input | 1 | Sensed SCL line |
| sda_in | input | 1 | Sensed SDA line |
| sda_oe | output | 1 | When 1 the pad pulls SDA low |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to write |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle strobe marking a byte fetched for sending |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
Writes are tried with a single byte and with a four-byte burst that crosses 0xFF. The burst shows whether the pointer steps and wraps, or whether every byte lands on one address. Reads are tried as a single byte behind a fresh pointer, as a three-byte burst across the wrap, and as a read with no pointer write. Together these separate a correct pointer load, a correct step per sent byte, and a pointer that is kept between transactions. Foreign addresses are sent under both strap settings to show that each strap accepts exactly its own address and that a rejected transaction leaves SDA and the strobes untouched. A line monitor watches every change of the SDA drive against the SCL level.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } rx_kind_e;

    typedef struct packed {
        tgt_state_e         st;
        rx_kind_e           kind;
        logic [BYTE_W-1:0]  sh;
        logic [CNT_W-1:0]   cnt;
        logic [PTR_W-1:0]   ptr;
        logic               rw;
        logic               oe;
        logic               wr;
        logic               rd;
        logic [BYTE_W-1:0]  wd;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_p_q;
    logic sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    assign start_ev = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_ev  = scl_s & scl_p_q & ~sda_p_q & sda_s;

    AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_ev, stop_ev})) else $error("bus events overlap"); // R8
endmodule

// File: rtl/i2c_regbus_target.sv
module i2c_regbus_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] ADDR_PRI = 7'h34,
    parameter logic [6:0] ADDR_ALT = 7'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_ev, stop_ev;
    logic [6:0] dev_addr;
    tgt_regs_t  q, d;

    i2c_sync2 #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_in, sda_in}),
        .sync_o  (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    assign dev_addr = addr_sel ? ADDR_ALT : ADDR_PRI;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        d.rd = 1'b0;
        if (start_ev) begin
            d.st   = ST_RX;
            d.kind = K_ADDR;
            d.cnt  = '0;
            d.oe   = 1'b0;
        end else if (stop_ev) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BITS_FULL) begin
                        d.cnt = '0;
                        case (q.kind)
                            K_ADDR: begin
                                if (q.sh[7:1] == dev_addr) begin
                                    d.rw = q.sh[0];
                                    d.oe = 1'b1;
                                    d.st = ST_RX_ACK;
                                end else begin
                                    d.st = ST_SKIP;
                                end
                            end
                            K_PTR: begin
                                d.ptr = q.sh;
                                d.oe  = 1'b1;
                                d.st  = ST_RX_ACK;
                            end
                            default: begin
                                d.wr = 1'b1;
                                d.wd = q.sh;
                                d.oe = 1'b1;
                                d.st = ST_RX_ACK;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.kind == K_ADDR && q.rw) begin
                            d.st = ST_TX;
                            d.sh = reg_rdata;
                            d.oe = ~reg_rdata[BYTE_W-1];
                            d.rd = 1'b1;
                        end else begin
                            d.st = ST_RX;
                            if (q.kind == K_DATA) d.ptr = q.ptr + 8'd1;
                            d.kind = (q.kind == K_ADDR) ? K_PTR : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == BITS_LAST) begin
                            d.oe  = 1'b0;
                            d.st  = ST_TX_ACK;
                            d.ptr = q.ptr + 8'd1;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe  = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise && sda_s) begin
                        d.st = ST_SKIP;
                    end else if (scl_fall) begin
                        d.st  = ST_TX;
                        d.cnt = '0;
                        d.sh  = reg_rdata;
                        d.oe  = ~reg_rdata[BYTE_W-1];
                        d.rd  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, kind: K_ADDR, sh: '0, cnt: '0, ptr: '0,
                   rw: 1'b0, oe: 1'b0, wr: 1'b0, rd: 1'b0, wd: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.oe;
    assign reg_addr  = q.ptr;
    assign reg_wdata = q.wd;
    assign reg_wr    = q.wr;
    assign reg_rd    = q.rd;

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s)) else $error("SDA drive rose with SCL high"); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd})) else $error("write and read strobe together"); // R4
    AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> sda_oe) else $error("write strobe without acknowledge"); // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != $past(reg_addr)) |->
            ((reg_addr == $past(reg_addr) + 8'd1) ||
             ($past(q.st) == ST_RX && $past(q.kind) == K_PTR))) else $error("pointer jumped"); // R5
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP) |-> (!sda_oe && !reg_wr && !reg_rd)) else $error("activity while ignoring"); // R3
endmodule

// File: tb/i2c_regbus_target_tb.sv
module i2c_regbus_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 16;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_sel = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_wr, reg_rd;

    logic [7:0] mem [256];
    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int oe_hi = 0;
    int line_viol = 0;
    logic prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_regbus_target u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
    end

    always @(negedge clk) begin
        if (sda_oe !== prev_oe && scl_m) line_viol++;
        if (sda_oe) oe_hi++;
        prev_oe = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(Q);
            scl_m = 1'b1; w(Q);
            scl_m = 1'b0; w(1);
        end
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q/2);
        acked = ~sda_bus;
        w(Q/2);
        scl_m = 1'b0; w(1);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            w(Q);
            scl_m = 1'b1; w(Q/2);
            b = {b[6:0], sda_bus};
            w(Q/2);
            scl_m = 1'b0; w(1);
        end
        w(2);
        sda_m = give_ack ? 1'b0 : 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        scl_m = 1'b0; w(1);
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        w(3);
        chk(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R1 reset quiet",
            {sda_oe, reg_wr, reg_rd}, 0);
    endtask

    task automatic t_single_write();
        bit a0, a1, a2;
        int wr0 = wr_cnt;
        bus_start();
        send_byte(8'h68, a0);
        send_byte(8'h10, a1);
        send_byte(8'hA5, a2);
        bus_stop();
        chk(a0, "R2 address 0x34 acked", a0, 1);
        chk(a1 && a2, "R4 pointer and data acked", {a1, a2}, 3);
        chk(mem[8'h10] == 8'hA5, "R4 data at pointer", mem[8'h10], 8'hA5);
        chk(wr_cnt == wr0 + 1, "R4 one write strobe", wr_cnt - wr0, 1);
        chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
    endtask

    task automatic t_burst_write();
        bit a;
        bit all = 1'b1;
        logic [7:0] vals [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        bus_start();
        send_byte(8'h68, a); all &= a;
        send_byte(8'hFE, a); all &= a;
        for (int i = 0; i < 4; i++) begin
            send_byte(vals[i], a); all &= a;
        end
        bus_stop();
        chk(all, "R4 burst write acked", all, 1);
        chk(mem[8'hFE] == 8'h11 && mem[8'hFF] == 8'h22, "R5 successive addresses",
            {mem[8'hFE], mem[8'hFF]}, 16'h1122);
        chk(mem[8'h00] == 8'h33 && mem[8'h01] == 8'h44, "R5 pointer wraps to 0x00",
            {mem[8'h00], mem[8'h01]}, 16'h3344);
    endtask

    task automatic t_ptr_read();
        bit a0, a1, a2;
        logic [7:0] b;
        int rd0 = rd_cnt;
        bus_start();
        send_byte(8'h68, a0);
        send_byte(8'h10, a1);
        bus_start();
        send_byte(8'h69, a2);
        recv_byte(1'b0, b);
        bus_stop();
        chk(a0 && a1 && a2, "R6 read header acked", {a0, a1, a2}, 7);
        chk(b == 8'hA5, "R6 read returns pointed register", b, 8'hA5);
        chk(rd_cnt == rd0 + 1, "R6 one read strobe", rd_cnt - rd0, 1);
        chk(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
    endtask

    task automatic t_burst_read();
        bit a;
        logic [7:0] b0, b1, b2;
        int rd0 = rd_cnt;
        bus_start();
        send_byte(8'h68, a);
        send_byte(8'hFE, a);
        bus_start();
        send_byte(8'h69, a);
        recv_byte(1'b1, b0);
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        chk(sda_oe == 1'b0, "R7 burst ended by NACK releases SDA", sda_oe, 0);
        bus_stop();
        chk({b0, b1, b2} == 24'h112233, "R7 burst read steps and wraps", {b0, b1, b2}, 24'h112233);
        chk(rd_cnt == rd0 + 3, "R6 read strobe per byte", rd_cnt - rd0, 3);
    endtask

    task automatic t_ptr_persist();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h69, a);
        recv_byte(1'b0, b);
        bus_stop();
        chk(a && b == 8'h44, "R9 pointer kept after burst", b, 8'h44);
    endtask

    task automatic t_foreign_addr();
        bit a0, a1, a2;
        int wr0 = wr_cnt;
        int rd0 = rd_cnt;
        int oe0 = oe_hi;
        bus_start();
        send_byte(8'h60, a0);
        send_byte(8'h10, a1);
        send_byte(8'h00, a2);
        bus_stop();
        chk(!a0 && !a1 && !a2, "R3 no acknowledge", {a0, a1, a2}, 0);
        chk(oe_hi == oe0, "R3 SDA never driven", oe_hi - oe0, 0);
        chk(wr_cnt == wr0 && rd_cnt == rd0 && mem[8'h10] == 8'hA5, "R3 no strobes",
            wr_cnt - wr0 + rd_cnt - rd0, 0);
    endtask

    task automatic t_alt_strap();
        bit a0, a1, a2, r0;
        int wr0;
        addr_sel = 1'b1;
        w(4);
        bus_start();
        send_byte(8'h60, a0);
        send_byte(8'h40, a1);
        send_byte(8'h9C, a2);
        bus_stop();
        chk(a0 && a1 && a2 && mem[8'h40] == 8'h9C, "R2 strap selects 0x30",
            mem[8'h40], 8'h9C);
        wr0 = wr_cnt;
        bus_start();
        send_byte(8'h68, r0);
        send_byte(8'h40, a1);
        send_byte(8'h00, a2);
        bus_stop();
        chk(!r0 && wr_cnt == wr0 && mem[8'h40] == 8'h9C, "R2 0x34 rejected under strap 1",
            r0, 0);
        addr_sel = 1'b0;
        w(4);
    endtask

    task automatic t_line_discipline();
        chk(line_viol == 0, "R8 drive changes only while SCL low", line_viol, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        w(5);
        rst_n = 1'b1;
        t_reset();
        t_single_write();
        t_burst_write();
        t_ptr_read();
        t_burst_read();
        t_ptr_persist();
        t_foreign_addr();
        t_alt_strap();
        t_line_discipline();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule